// File: doc/BRIEF.md
# CEC Signal Free Time Gate

This block decides when a CEC transmitter is allowed to begin driving the bus. After it is armed, it counts the time the bus line stays high (idle) in half nominal bit periods. When the count reaches a programmable threshold, it raises `bus_free`. The threshold comes from a 3-bit code. Codes 1 to 7 give a fixed idle time. Code 0 hands the choice to a small history register, which remembers how the last transfer ended.

A mode input selects when counting is armed:
- From software's start-of-message request.
- Automatically at the end of any transmitted or received message.

The half-period tick, the transmit shifter and arbitration are outside this block. The block only consumes the tick and the end-of-transfer pulses.

Top module: `cec_sft_gate`

## Requirements
- R1: After reset, `bus_free` is low, no counting is in progress, and the history state selects the new-initiator threshold of 9 half periods.
- R2: For `sft_code` c in 1..7, `bus_free` rises after 2c-1 counted `half_tick` pulses from arming. That is 0.5, 1.5, ... 6.5 bit periods.
- R3: `half_tick` pulses have no effect on `bus_free` while the block is not armed.
- R4: With `sft_code` 0, the threshold follows the last transfer:
  - 5 half periods after `tx_done` with `tx_fail`=1.
  - 13 half periods after `tx_done` with `tx_fail`=0.
  - 9 half periods after `rx_done`, or after reset.
- R5: With `start_on_end`=0, `som_req` arms the count from zero and clears `bus_free`. `tx_done` and `rx_done` do not arm.
- R6: With `start_on_end`=1, either `tx_done` or `rx_done` arms the count from zero. In this mode, `som_req` does not arm; it clears `bus_free` and stops counting.
- R7: A low `line_in` while armed or free clears the count and drops `bus_free` on the next cycle. Counting then restarts from zero.
- R8: `bus_free` rises in the cycle after the tick whose count reaches the threshold. It stays high through further ticks until one of these occurs: a start of message, an arming event, a low line, or disable.
- R9: `enable` low clears the count, `bus_free` and the history state to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state |
| sft_code | input | 3 | Idle-time code; 0 selects the history-based threshold |
| start_on_end | input | 1 | 1: arm at end of message; 0: arm on start-of-message request |
| som_req | input | 1 | One-cycle software start-of-message strobe |
| tx_done | input | 1 | One-cycle end-of-transmission pulse |
| tx_fail | input | 1 | Qualifies `tx_done`: the transmission failed |
| rx_done | input | 1 | One-cycle end-of-reception pulse |
| line_in | input | 1 | Sampled bus line, 1 = idle (high) |
| half_tick | input | 1 | One-cycle pulse at twice the nominal bit rate |
| bus_free | output | 1 | Line has been idle long enough; a transmission may start |

## Verification
The assertions assume the following about the inputs:
- `som_req`, `tx_done`, `rx_done` and `half_tick` are single-cycle pulses.
- `tx_fail` has meaning only alongside `tx_done`.
- `line_in` is already synchronized to `clk`.

The stimulus respects these assumptions. Every strobe is driven high for exactly one clock between falling edges. Ticks are never issued in the same cycle as an arming pulse. The code and the mode bit are changed only while the block is idle or between scenarios.

// File: rtl/cec_sft_pkg.sv
package cec_sft_pkg;

  // Outcome of the most recent transfer, used by the history threshold
  typedef enum logic [1:0] {
    HIST_NEW   = 2'd0,
    HIST_RETRY = 2'd1,
    HIST_SAME  = 2'd2
  } hist_e;

  typedef enum logic [1:0] {
    CNT_IDLE = 2'd0,
    CNT_RUN  = 2'd1,
    CNT_FREE = 2'd2
  } cnt_state_e;

endpackage

// File: rtl/cec_sft_history.sv
module cec_sft_history
  import cec_sft_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  tx_done,
  input  logic  tx_fail,
  input  logic  rx_done,
  output hist_e hist
);

  hist_e hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (tx_done) begin
      hist_d = tx_fail ? HIST_RETRY : HIST_SAME;
    end else if (rx_done) begin
      hist_d = HIST_NEW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= HIST_NEW;
    end else if (!enable) begin
      hist_q <= HIST_NEW;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign hist = hist_q;

endmodule

// File: rtl/cec_sft_threshold.sv
module cec_sft_threshold
  import cec_sft_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 4,
  parameter int RETRY_HALF = 5,
  parameter int NEW_HALF   = 9,
  parameter int SAME_HALF  = 13
) (
  input  logic [CODE_W-1:0] code,
  input  hist_e             hist,
  output logic [CNT_W-1:0]  thr
);

  always_comb begin
    if (code == '0) begin
      unique case (hist)
        HIST_RETRY: thr = CNT_W'(RETRY_HALF);
        HIST_SAME:  thr = CNT_W'(SAME_HALF);
        default:    thr = CNT_W'(NEW_HALF);
      endcase
    end else begin
      // 0.5 + (code-1) periods, in half periods: 2*code - 1
      thr = CNT_W'((2 * int'(code)) - 1);
    end
  end

endmodule

// File: rtl/cec_sft_counter.sv
module cec_sft_counter
  import cec_sft_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             arm,
  input  logic             stop,
  input  logic             line_in,
  input  logic             half_tick,
  input  logic [CNT_W-1:0] thr,
  output logic             free
);

  cnt_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (arm) begin
      st_d  = CNT_RUN;
      cnt_d = '0;
    end else if (stop) begin
      st_d  = CNT_IDLE;
      cnt_d = '0;
    end else if ((st_q != CNT_IDLE) && !line_in) begin
      st_d  = CNT_RUN;
      cnt_d = '0;
    end else if ((st_q == CNT_RUN) && half_tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc >= thr) begin
        st_d = CNT_FREE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CNT_IDLE;
      cnt_q <= '0;
    end else if (!enable) begin
      st_q  <= CNT_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign free = (st_q == CNT_FREE);

endmodule

// File: rtl/cec_sft_gate.sv
module cec_sft_gate
  import cec_sft_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int RETRY_HALF = 5,
  parameter int NEW_HALF   = 9,
  parameter int SAME_HALF  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] sft_code,
  input  logic              start_on_end,
  input  logic              som_req,
  input  logic              tx_done,
  input  logic              tx_fail,
  input  logic              rx_done,
  input  logic              line_in,
  input  logic              half_tick,
  output logic              bus_free
);

  localparam int CODE_MAX_HALF = 2 * ((1 << CODE_W) - 1) - 1;
  localparam int HM1           = (RETRY_HALF > NEW_HALF) ? RETRY_HALF : NEW_HALF;
  localparam int HIST_MAX_HALF = (HM1 > SAME_HALF) ? HM1 : SAME_HALF;
  localparam int MAX_HALF      = (CODE_MAX_HALF > HIST_MAX_HALF) ? CODE_MAX_HALF : HIST_MAX_HALF;
  localparam int CNT_W         = $clog2(MAX_HALF + 1);

  hist_e            hist;
  logic [CNT_W-1:0] thr;
  logic             arm;
  logic             stop;

  assign arm  = start_on_end ? (tx_done | rx_done) : som_req;
  assign stop = start_on_end & som_req;

  cec_sft_history u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .tx_done (tx_done),
    .tx_fail (tx_fail),
    .rx_done (rx_done),
    .hist    (hist)
  );

  cec_sft_threshold #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .RETRY_HALF (RETRY_HALF),
    .NEW_HALF   (NEW_HALF),
    .SAME_HALF  (SAME_HALF)
  ) u_thr (
    .code (sft_code),
    .hist (hist),
    .thr  (thr)
  );

  cec_sft_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .arm       (arm),
    .stop      (stop),
    .line_in   (line_in),
    .half_tick (half_tick),
    .thr       (thr),
    .free      (bus_free)
  );

endmodule

// File: rtl/cec_sft_gate_chk.sv
module cec_sft_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic start_on_end,
  input logic som_req,
  input logic tx_done,
  input logic rx_done,
  input logic line_in,
  input logic half_tick,
  input logic bus_free
);

  // R9: disable drops the output
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_free);

  // R7: low line drops the output
  p_line_low_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_in |=> !bus_free);

  // R8: output only rises on a tick with an idle line
  p_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> ($past(half_tick) && $past(line_in) && $past(enable)));

  // R8: output holds while nothing disturbs it
  p_free_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && enable && line_in && !som_req && !tx_done && !rx_done) |=> bus_free);

  // R5 / R6: a start-of-message request always leaves the output low
  p_som_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    som_req |=> !bus_free);

  // R6: end of message in end-start mode restarts the count
  p_end_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_on_end && (tx_done || rx_done)) |=> !bus_free);

endmodule

bind cec_sft_gate cec_sft_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .start_on_end (start_on_end),
  .som_req      (som_req),
  .tx_done      (tx_done),
  .rx_done      (rx_done),
  .line_in      (line_in),
  .half_tick    (half_tick),
  .bus_free     (bus_free)
);

// File: tb/cec_sft_gate_bench.sv
module cec_sft_gate_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic [2:0] sft_code;
  logic       start_on_end;
  logic       som_req;
  logic       tx_done;
  logic       tx_fail;
  logic       rx_done;
  logic       line_in;
  logic       half_tick;
  logic       bus_free;

  int n_run;
  int n_fail;
  bit finished;

  cec_sft_gate u_cec_sft_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sft_code     (sft_code),
    .start_on_end (start_on_end),
    .som_req      (som_req),
    .tx_done      (tx_done),
    .tx_fail      (tx_fail),
    .rx_done      (rx_done),
    .line_in      (line_in),
    .half_tick    (half_tick),
    .bus_free     (bus_free)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic exp, input string tag);
    n_run++;
    if (bus_free !== exp) begin
      n_fail++;
      $display("FAIL %s: bus_free=%0b expected %0b", tag, bus_free, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic pulse_som();
    @(negedge clk); som_req = 1'b1;
    @(negedge clk); som_req = 1'b0;
  endtask

  task automatic pulse_tx(input logic fail);
    @(negedge clk); tx_done = 1'b1; tx_fail = fail;
    @(negedge clk); tx_done = 1'b0; tx_fail = 1'b0;
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
  endtask

  task automatic pulse_disable();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic tick();
    @(negedge clk); half_tick = 1'b1;
    @(negedge clk); half_tick = 1'b0;
  endtask

  // n ticks: output low until the n-th, high after it, high on one extra
  task automatic expect_rise(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      tick();
      check(i == n, tag);
    end
    tick();
    check(1'b1, {tag, " hold R8"});
  endtask

  task automatic expect_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) tick();
    check(1'b0, tag);
  endtask

  task automatic t_reset();
    check(1'b0, "R1 reset");
    expect_quiet(15, "R3 unarmed ticks");
  endtask

  task automatic t_codes();
    start_on_end = 1'b0;
    for (int c = 1; c <= 7; c++) begin
      sft_code = 3'(c);
      pulse_som();
      check(1'b0, "R5 som clears");
      expect_rise(2 * c - 1, "R2 code");
    end
  endtask

  task automatic t_history();
    start_on_end = 1'b0;
    sft_code = 3'd0;
    pulse_disable();
    pulse_som();
    expect_rise(9, "R4 reset history");
    pulse_tx(1'b1);
    pulse_som();
    expect_rise(5, "R4 failed tx");
    pulse_tx(1'b0);
    pulse_som();
    expect_rise(13, "R4 same initiator");
    pulse_rx();
    pulse_som();
    expect_rise(9, "R4 new initiator");
  endtask

  task automatic t_opt_clear();
    start_on_end = 1'b0;
    sft_code = 3'd2;
    pulse_disable();
    check(1'b0, "R9 disable drops");
    pulse_rx();
    pulse_tx(1'b0);
    expect_quiet(15, "R5 done does not arm");
  endtask

  task automatic t_opt_set();
    start_on_end = 1'b1;
    sft_code = 3'd2;
    pulse_som();
    expect_quiet(15, "R6 som does not arm");
    pulse_tx(1'b0);
    expect_rise(3, "R6 tx end arms");
    pulse_som();
    check(1'b0, "R6 som drops");
    expect_quiet(15, "R6 som stops");
    pulse_rx();
    expect_rise(3, "R6 rx end arms");
    start_on_end = 1'b0;
  endtask

  task automatic t_line();
    start_on_end = 1'b0;
    sft_code = 3'd3;
    pulse_som();
    for (int i = 0; i < 3; i++) tick();
    check(1'b0, "R7 partial");
    @(negedge clk); line_in = 1'b0;
    @(negedge clk); line_in = 1'b1;
    expect_rise(5, "R7 restart");
    @(negedge clk); line_in = 1'b0;
    @(negedge clk); line_in = 1'b1;
    check(1'b0, "R7 low drops free");
    expect_rise(5, "R7 recount");
  endtask

  task automatic t_disable();
    start_on_end = 1'b0;
    sft_code = 3'd0;
    pulse_tx(1'b0);
    pulse_disable();
    pulse_som();
    expect_rise(9, "R9 history cleared");
    pulse_som();
    for (int i = 0; i < 4; i++) tick();
    pulse_disable();
    expect_quiet(15, "R9 count cleared");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    enable = 1'b1;
    sft_code = 3'd1;
    start_on_end = 1'b0;
    som_req = 1'b0;
    tx_done = 1'b0;
    tx_fail = 1'b0;
    rx_done = 1'b0;
    line_in = 1'b1;
    half_tick = 1'b0;
    repeat (3) idle_cycle();
    rst_n = 1'b1;
    idle_cycle();
    t_reset();
    t_codes();
    t_history();
    t_opt_clear();
    t_opt_set();
    t_line();
    t_disable();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule